// File: doc/BRIEF.md
# Byte-Lane Memory Control Decoder

This block models the control side of an asynchronous 16-bit static-style memory on a synchronous fabric. A fast internal clock samples the control pins once per cycle. The pins are two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and two active-low byte enables. From each sample the block picks one of four operating modes. It then drives a read-data word with one output-enable bit per byte lane, so that a wrapper can resolve a tri-state bus, and it raises a standby flag whenever the device counts as deselected.

Writes go into a small parameterised word array, one byte lane at a time. The write window is open while the write strobe, both chip selects and at least one byte enable are all asserted. Data is stored when that window closes, whichever of those signals closes it. The address, data and lane mask stored are the ones from the last sample taken while the window was still open.

Top module: `byte_lane_mem_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `standby` is 1, `mode` is 0, `lane_oe` is 0 and `rdata` is 0.
- R2: The device is deselected when `en_lo_n` is 1, or `en_hi` is 0, or both bits of `be_n` are 1 (bit 0 is the lower byte, bits 7:0; bit 1 is the upper byte, bits 15:8). When deselected, `mode` is 0 (standby), `standby` is 1 and `lane_oe` is 0.
- R3: When selected with `wr_n`=1 and `oe_n`=0, `mode` is 1 (read), `standby` is 0, `lane_oe[0]` is the inverse of `be_n[0]` and `lane_oe[1]` is the inverse of `be_n[1]`.
- R4: Each byte lane of `rdata` carries the stored byte at the sampled `addr` when its `lane_oe` bit is 1, and is 0 otherwise.
- R5: When selected with `wr_n`=1 and `oe_n`=1, `mode` is 2 (output disabled), `lane_oe` is 0 and `standby` is 0.
- R6: When selected with `wr_n`=0, `mode` is 3 (write) whatever `oe_n` is. `lane_oe` is 0 and `standby` is 0.
- R7: A write changes only the byte lanes whose `be_n` bit was 0 in the last sample of the window. The other lanes keep their contents.
- R8: Data is stored only when the write window closes. The window closes on `wr_n` rising, `en_lo_n` rising, `en_hi` falling, or both byte enables going high. The address and data stored are those of the last open sample. Values presented in the closing sample are not stored.
- R9: Every output reflects the pins sampled at the previous rising clock edge. A stored write can be read back from the cycle after the closing sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| en_lo_n | input | 1 | Active-low chip select |
| en_hi | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| be_n | input | 2 | Active-low byte enables, bit 0 lower lane, bit 1 upper lane |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Inbound half of the data bus |
| rdata | output | 16 | Outbound half of the data bus |
| lane_oe | output | 2 | Per-lane drive enable for the bus wrapper |
| mode | output | 2 | 0 standby, 1 read, 2 output disabled, 3 write |
| standby | output | 1 | High in every deselect case |

## Verification
The assertions assume that the pins settle between clock edges and that every pin is a known 0 or 1 at each edge. They relate each output to the pins one edge earlier, so a pin that changes at the edge itself would make that relation ambiguous. The bench changes every pin only on the falling edge of the clock and never drives an unknown value. It also writes every word once before it compares any read, so the array never returns an unwritten value to a check.

// File: rtl/blm_pkg.sv
package blm_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_ODIS  = 2'd2,
        MODE_WRITE = 2'd3
    } mode_e;

    typedef struct packed {
        logic             en_lo_n;
        logic             en_hi;
        logic             wr_n;
        logic             oe_n;
        logic [LANES-1:0] be_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{en_lo_n: 1'b1, en_hi: 1'b0, wr_n: 1'b1,
                                  oe_n: 1'b1, be_n: '1};

    function automatic logic is_sel(ctl_t c);
        return !c.en_lo_n && c.en_hi && !(&c.be_n);
    endfunction

    function automatic logic in_window(ctl_t c);
        return is_sel(c) && !c.wr_n;
    endfunction

    function automatic mode_e mode_of(ctl_t c);
        mode_e m;
        if (!is_sel(c))
            m = MODE_STBY;
        else if (!c.wr_n)
            m = MODE_WRITE;
        else if (!c.oe_n)
            m = MODE_READ;
        else
            m = MODE_ODIS;
        return m;
    endfunction

endpackage

// File: rtl/blm_sampler.sv
module blm_sampler
    import blm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              win_i,
    input  logic [LANES-1:0]  lanes_i,
    output ctl_t              cur_ctl,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              prv_win,
    output logic [ADDR_W-1:0] prv_addr,
    output logic [WORD_W-1:0] prv_data,
    output logic [LANES-1:0]  prv_lanes
);

    logic [WORD_W-1:0] cur_data;

    // first stage: raw pin sample
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ctl  <= CTL_IDLE;
            cur_addr <= '0;
            cur_data <= '0;
        end else begin
            cur_ctl  <= ctl_i;
            cur_addr <= addr_i;
            cur_data <= data_i;
        end
    end

    // second stage: what the window looked like one sample ago
    always_ff @(posedge clk) begin
        if (rst) begin
            prv_win   <= 1'b0;
            prv_addr  <= '0;
            prv_data  <= '0;
            prv_lanes <= '0;
        end else begin
            prv_win   <= win_i;
            prv_addr  <= cur_addr;
            prv_data  <= cur_data;
            prv_lanes <= lanes_i;
        end
    end

endmodule

// File: rtl/blm_decode.sv
module blm_decode
    import blm_pkg::*;
(
    input  ctl_t             cur_ctl,
    input  logic             prv_win,
    output mode_e            mode,
    output logic [LANES-1:0] lane_oe,
    output logic             standby,
    output logic             win_now,
    output logic [LANES-1:0] lanes_now,
    output logic             commit
);

    always_comb begin
        mode      = mode_of(cur_ctl);
        standby   = (mode == MODE_STBY);
        win_now   = in_window(cur_ctl);
        lanes_now = ~cur_ctl.be_n;
        lane_oe   = (mode == MODE_READ) ? ~cur_ctl.be_n : '0;
        // falling edge of the overlap window
        commit    = prv_win && !win_now;
    end

endmodule

// File: rtl/blm_array.sv
module blm_array
    import blm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [LANES-1:0]  rd_lanes,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g])
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_lanes[g] ? store[raddr] : '0;
    end

endmodule

// File: rtl/byte_lane_mem_ctrl.sv
module byte_lane_mem_ctrl
    import blm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_lo_n,
    input  logic              en_hi,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  lane_oe,
    output logic [1:0]        mode,
    output logic              standby
);

    ctl_t              pins;
    ctl_t              cur_ctl;
    logic [ADDR_W-1:0] cur_addr;
    logic              prv_win;
    logic [ADDR_W-1:0] prv_addr;
    logic [WORD_W-1:0] prv_data;
    logic [LANES-1:0]  prv_lanes;
    logic              win_now;
    logic [LANES-1:0]  lanes_now;
    logic              commit;
    mode_e             mode_int;

    assign pins = '{en_lo_n: en_lo_n, en_hi: en_hi, wr_n: wr_n,
                    oe_n: oe_n, be_n: be_n};

    blm_sampler #(.ADDR_W(ADDR_W)) u_smp (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (pins),
        .addr_i    (addr),
        .data_i    (wdata),
        .win_i     (win_now),
        .lanes_i   (lanes_now),
        .cur_ctl   (cur_ctl),
        .cur_addr  (cur_addr),
        .prv_win   (prv_win),
        .prv_addr  (prv_addr),
        .prv_data  (prv_data),
        .prv_lanes (prv_lanes)
    );

    blm_decode u_dec (
        .cur_ctl   (cur_ctl),
        .prv_win   (prv_win),
        .mode      (mode_int),
        .lane_oe   (lane_oe),
        .standby   (standby),
        .win_now   (win_now),
        .lanes_now (lanes_now),
        .commit    (commit)
    );

    blm_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk      (clk),
        .wr_en    (commit && !rst),
        .wr_lanes (prv_lanes),
        .waddr    (prv_addr),
        .wdata    (prv_data),
        .raddr    (cur_addr),
        .rd_lanes (lane_oe),
        .rdata    (rdata)
    );

    assign mode = mode_int;

endmodule

// File: rtl/blm_chk.sv
module blm_chk
    import blm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en_lo_n,
    input logic             en_hi,
    input logic             wr_n,
    input logic             oe_n,
    input logic [LANES-1:0] be_n,
    input logic [LANES-1:0] lane_oe,
    input logic [1:0]       mode,
    input logic             standby
);

    // R2
    quiet_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
        standby |-> (lane_oe == '0 && mode == MODE_STBY));

    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(en_lo_n) || !$past(en_hi) || $past(&be_n)))
        |-> standby);

    // R3
    lane_lo_chk: assert property (@(posedge clk) disable iff (rst)
        lane_oe[0] |-> (!$past(be_n[0]) && !$past(oe_n) && mode == MODE_READ));

    // R3
    lane_hi_chk: assert property (@(posedge clk) disable iff (rst)
        lane_oe[1] |-> (!$past(be_n[1]) && !$past(oe_n) && mode == MODE_READ));

    // R6
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_n) && !$past(en_lo_n) && $past(en_hi)
         && !$past(&be_n)) |-> (mode == MODE_WRITE && lane_oe == '0 && !standby));

    // R5
    out_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_n) && $past(oe_n) && !$past(en_lo_n)
         && $past(en_hi) && !$past(&be_n)) |-> (mode == MODE_ODIS && lane_oe == '0));

endmodule

bind byte_lane_mem_ctrl blm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_lo_n (en_lo_n),
    .en_hi   (en_hi),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .be_n    (be_n),
    .lane_oe (lane_oe),
    .mode    (mode),
    .standby (standby)
);

// File: tb/byte_lane_mem_ctrl_tb.sv
`timescale 1ns/1ps
module byte_lane_mem_ctrl_tb;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_lo_n = 1'b1, en_hi = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
    logic [1:0]    be_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    lane_oe;
    logic [1:0]    mode;
    logic          standby;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";

    // reference state: sampled pins (s_*), one sample earlier (p_*)
    logic [15:0] ref_mem [DEPTH];
    logic s_elo, s_ehi, s_wr, s_oe;  logic [1:0] s_be;  int s_a;  logic [15:0] s_d;
    logic p_win;  logic [1:0] p_be;  int p_a;  logic [15:0] p_d;

    always #5 clk = ~clk;

    byte_lane_mem_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .en_lo_n(en_lo_n), .en_hi(en_hi), .wr_n(wr_n),
        .oe_n(oe_n), .be_n(be_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .lane_oe(lane_oe), .mode(mode), .standby(standby)
    );

    function automatic logic ref_sel();
        return !s_elo && s_ehi && (s_be != 2'b11);
    endfunction

    function automatic int ref_mode();
        if (!ref_sel()) return 0;
        if (!s_wr)      return 3;
        if (!s_oe)      return 1;
        return 2;
    endfunction

    function automatic string mode_req(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model_edge();
        logic now_win;
        if (rst) begin
            s_elo = 1; s_ehi = 0; s_wr = 1; s_oe = 1; s_be = 2'b11; s_a = 0; s_d = 0;
            p_win = 0; p_be = 0; p_a = 0; p_d = 0;
        end else begin
            now_win = ref_sel() && !s_wr;
            if (p_win && !now_win) begin
                if (!p_be[0]) ref_mem[p_a][7:0]  = p_d[7:0];
                if (!p_be[1]) ref_mem[p_a][15:8] = p_d[15:8];
            end
            p_win = now_win; p_be = s_be; p_a = s_a; p_d = s_d;
            s_elo = en_lo_n; s_ehi = en_hi; s_wr = wr_n; s_oe = oe_n;
            s_be = be_n; s_a = int'(addr); s_d = wdata;
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t",
                     req, phase, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int m;
        logic [1:0] e_oe;
        logic [15:0] e_rd;
        m    = ref_mode();
        e_oe = (m == 1) ? ~s_be : 2'b00;
        e_rd = ref_mem[s_a];
        if (!e_oe[0]) e_rd[7:0]  = 8'h00;
        if (!e_oe[1]) e_rd[15:8] = 8'h00;
        check(mode_req(m), "mode",    int'(mode),    m);
        check(mode_req(m), "standby", int'(standby), (m == 0) ? 1 : 0);
        check(mode_req(m), "lane_oe", int'(lane_oe), int'(e_oe));
        check("R4",        "rdata",   int'(rdata),   int'(e_rd));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        #2;
        compare();
        @(negedge clk);
    endtask

    task automatic pins(logic elo, logic ehi, logic w, logic o, logic [1:0] be,
                        int a, logic [15:0] d);
        en_lo_n = elo; en_hi = ehi; wr_n = w; oe_n = o; be_n = be;
        addr = AW'(a); wdata = d;
    endtask

    task automatic do_write(int a, logic [15:0] d, logic [1:0] be);
        pins(0, 1, 0, 1, be, a, d);     cycle();
        pins(0, 1, 1, 1, be, a, 16'h0); cycle();
    endtask

    task automatic do_read(int a, logic [1:0] be);
        pins(0, 1, 1, 0, be, a, 16'h0); cycle();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        // R1: reset state, held and just after release
        repeat (3) cycle();
        rst = 1'b0;
        cycle();

        // fill every word so no read sees unwritten storage (R7 full-lane writes)
        phase = "R7";
        for (int i = 0; i < DEPTH; i++) do_write(i, 16'(i * 16'h0101 + 16'h1357), 2'b00);

        // R3 / R4: reads under each byte-enable pattern
        phase = "R3";
        do_read(5, 2'b00); do_read(5, 2'b10); do_read(9, 2'b01);
        do_read(DEPTH - 1, 2'b00); do_read(0, 2'b00);
        // R2: both byte enables high deselects
        phase = "R2";
        do_read(5, 2'b11);
        pins(1, 1, 1, 0, 2'b00, 5, 0); cycle();
        pins(0, 0, 1, 0, 2'b00, 5, 0); cycle();
        pins(1, 0, 0, 0, 2'b00, 5, 16'hdead); cycle();
        // R5: output disabled
        phase = "R5";
        pins(0, 1, 1, 1, 2'b00, 7, 0); cycle();
        // R6: write overrides output enable
        phase = "R6";
        pins(0, 1, 0, 0, 2'b00, 7, 16'hbeef); cycle();
        pins(0, 1, 1, 0, 2'b00, 7, 0); cycle();
        // R9: stored value is visible on the read that follows the close
        phase = "R9";
        do_read(7, 2'b00);

        // R7: single-lane writes keep the other lane
        phase = "R7";
        do_write(12, 16'haa55, 2'b10); do_read(12, 2'b00);
        do_write(13, 16'h66cc, 2'b01); do_read(13, 2'b00);

        // R8: each terminating signal, and last-open-sample capture
        phase = "R8";
        pins(0, 1, 0, 1, 2'b00, 20, 16'h1111); cycle();
        pins(0, 1, 0, 1, 2'b00, 21, 16'h2222); cycle();
        pins(1, 1, 0, 1, 2'b00, 22, 16'h3333); cycle();   // chip select low-side ends it
        do_read(21, 2'b00); do_read(20, 2'b00); do_read(22, 2'b00);
        pins(0, 1, 0, 1, 2'b00, 24, 16'h4444); cycle();
        pins(0, 0, 0, 1, 2'b00, 24, 16'h5555); cycle();   // high-side select ends it
        do_read(24, 2'b00);
        pins(0, 1, 0, 1, 2'b01, 25, 16'h6677); cycle();
        pins(0, 1, 0, 1, 2'b11, 25, 16'h8899); cycle();   // byte enables end it
        do_read(25, 2'b00);
        pins(0, 1, 0, 1, 2'b00, 26, 16'habcd); cycle();
        pins(0, 1, 1, 0, 2'b00, 26, 16'h0f0f); cycle();   // write strobe ends it, straight into read
        do_read(26, 2'b00);

        // mixed random traffic against the reference
        phase = "R9";
        for (int i = 0; i < 400; i++) begin
            pins(1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) != 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), $urandom_range(0, DEPTH - 1),
                 16'($urandom));
            cycle();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule